// File: doc/BRIEF.md
# Multichannel SPI Master Channel Scheduler

This block decides which of several SPI master channels is given the single shared shift register next. Channels are visited in a rotating order. The search for the next candidate always begins just after the channel that was served most recently. A channel is passed over when it is not currently allowed to send. That depends on its enable, its transmit holding state, its receive holding state and its mode. A channel is either in transmit-and-receive mode or in transmit-only mode.

The shifter reports the end of every word with a one-cycle pulse. On that pulse the scheduler frees the shift register and picks the next eligible channel in the same evaluation. It then issues a one-cycle load strobe with the new channel index. In parallel it tells the receive path which channel the completed word belongs to. If the first enabled channel in the rotation has nothing to send when a grant is made, an underflow event pulses and the arbiter moves on instead of stalling. With nothing eligible, the scheduler stays idle and looks again every cycle. The block also gates each channel's receive-full request, which is used both for the interrupt and for the DMA read request.

Top module: `spi_chan_sched`

## Requirements
- R1: A channel whose `ch_en` bit is 0 is never granted.
- R2: The search for the next grant starts at the channel after the last granted one and wraps from NCH-1 to 0. After reset the first channel searched is channel 0.
- R3: A channel whose `tx_empty` bit is 1 is never granted.
- R4: When a grant is issued and the first enabled channel in the search order has `tx_empty`=1, `tx_underflow` pulses for one cycle together with `load_stb`. It never pulses without `load_stb`.
- R5: In transmit-and-receive mode (`ch_txonly` bit = 0), a channel whose `rx_full` bit is 1 is skipped.
- R6: In transmit-only mode (`ch_txonly` bit = 1), `rx_full` has no effect on whether the channel is granted.
- R7: `rx_req[i]` equals `rx_full[i]` AND NOT `ch_txonly[i]`, registered one cycle.
- R8: After a grant, no new grant is issued until `word_done` pulses. A grant chosen in the `word_done` cycle shows `load_stb`=1 and the new `grant_idx` one cycle later. `load_stb` lasts one cycle.
- R9: One cycle after a `word_done` pulse that ends a granted word, `store_stb` pulses with `store_idx` equal to the channel that was being served. A `word_done` pulse while idle is ignored.
- R10: While no channel is eligible and the shifter is free, there is no grant and `grant_idx` holds its value. Once a channel becomes eligible, it is granted one cycle later.
- R11: During reset, `load_stb`, `tx_underflow`, `store_stb`, `rx_req` and `grant_idx` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_en | input | NCH | Per-channel enable |
| ch_txonly | input | NCH | Per-channel mode: 1 = transmit-only, 0 = transmit-and-receive |
| tx_empty | input | NCH | Per-channel transmit register/FIFO empty |
| rx_full | input | NCH | Per-channel receive register/FIFO full |
| word_done | input | 1 | End-of-word pulse from the shifter |
| grant_idx | output | $clog2(NCH) | Channel currently holding the shift register |
| load_stb | output | 1 | One-cycle strobe: load the granted channel's transmit data |
| tx_underflow | output | 1 | One-cycle transmit-underflow event |
| store_stb | output | 1 | One-cycle strobe: write the received word to `store_idx` |
| store_idx | output | $clog2(NCH) | Channel that owns the completed received word |
| rx_req | output | NCH | Per-channel gated receive-full request (interrupt and DMA read) |

## Verification
The embedded properties check the following on every cycle:
- every grant goes to a channel that was enabled, had data and was not blocked by a full receive side;
- no grant is made while a word is shifting;
- an idle shifter with an eligible channel always grants on the next cycle;
- underflow and store pulses have their causes;
- gated receive requests never appear for transmit-only channels.

Only the bench's scenarios can show:
- the exact rotation order and the wrap-around;
- which channel an underflow skips past;
- that the store index names the channel just served;
- that a stray end-of-word pulse while idle is ignored.

// File: rtl/spi_sched_pkg.sv
package spi_sched_pkg;
    typedef enum logic {
        MODE_TXRX   = 1'b0,
        MODE_TXONLY = 1'b1
    } chan_mode_e;
endpackage

// File: rtl/spi_chan_elig.sv
module spi_chan_elig
    import spi_sched_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic [NCH-1:0] en,
    input  logic [NCH-1:0] txonly,
    input  logic [NCH-1:0] txe,
    input  logic [NCH-1:0] rxf,
    output logic [NCH-1:0] elig,
    output logic [NCH-1:0] rxreq
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        chan_mode_e mode;
        logic       rx_blocks;
        always_comb begin
            mode      = chan_mode_e'(txonly[i]);
            rx_blocks = (mode == MODE_TXRX) && rxf[i];
            elig[i]   = en[i] && !txe[i] && !rx_blocks;
            rxreq[i]  = rxf[i] && (mode != MODE_TXONLY);
        end
    end
endmodule

// File: rtl/spi_rr_pick.sv
module spi_rr_pick #(
    parameter int NCH = 4,
    localparam int IW = $clog2(NCH)
) (
    input  logic [NCH-1:0] mask,
    input  logic [IW-1:0]  last,
    output logic           found,
    output logic [IW-1:0]  idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = NCH; k >= 1; k--) begin
            int p;
            p = int'(last) + k;
            if (p >= NCH) p = p - NCH;
            if (mask[p]) begin
                found = 1'b1;
                idx   = IW'(p);
            end
        end
    end
endmodule

// File: rtl/spi_chan_sched.sv
module spi_chan_sched #(
    parameter int NCH = 4,
    localparam int IW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] ch_en,
    input  logic [NCH-1:0] ch_txonly,
    input  logic [NCH-1:0] tx_empty,
    input  logic [NCH-1:0] rx_full,
    input  logic           word_done,
    output logic [IW-1:0]  grant_idx,
    output logic           load_stb,
    output logic           tx_underflow,
    output logic           store_stb,
    output logic [IW-1:0]  store_idx,
    output logic [NCH-1:0] rx_req
);
    localparam logic [NCH-1:0] ONE = NCH'(1);

    typedef struct packed {
        logic           busy;
        logic [IW-1:0]  last;
        logic [IW-1:0]  gidx;
        logic           load;
        logic           unf;
        logic           store;
        logic [IW-1:0]  sidx;
        logic [NCH-1:0] rxreq;
    } state_t;

    state_t st_q, st_d;

    logic [NCH-1:0] elig, rxreq_d;
    logic           pick_found, cand_found;
    logic [IW-1:0]  pick_idx, cand_idx;
    logic           free;

    spi_chan_elig #(.NCH(NCH)) u_elig (
        .en(ch_en), .txonly(ch_txonly), .txe(tx_empty), .rxf(rx_full),
        .elig(elig), .rxreq(rxreq_d)
    );

    spi_rr_pick #(.NCH(NCH)) u_pick (
        .mask(elig), .last(st_q.last), .found(pick_found), .idx(pick_idx)
    );

    spi_rr_pick #(.NCH(NCH)) u_cand (
        .mask(ch_en), .last(st_q.last), .found(cand_found), .idx(cand_idx)
    );

    always_comb begin
        st_d       = st_q;
        st_d.load  = 1'b0;
        st_d.unf   = 1'b0;
        st_d.store = 1'b0;
        st_d.rxreq = rxreq_d;
        free       = !st_q.busy || word_done;
        if (st_q.busy && word_done) begin
            st_d.busy  = 1'b0;
            st_d.store = 1'b1;
            st_d.sidx  = st_q.gidx;
        end
        if (free && pick_found) begin
            st_d.busy = 1'b1;
            st_d.gidx = pick_idx;
            st_d.last = pick_idx;
            st_d.load = 1'b1;
            st_d.unf  = cand_found && tx_empty[cand_idx];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.last <= IW'(NCH - 1);
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_idx    = st_q.gidx;
    assign load_stb     = st_q.load;
    assign tx_underflow = st_q.unf;
    assign store_stb    = st_q.store;
    assign store_idx    = st_q.sidx;
    assign rx_req       = st_q.rxreq;

    // R1 / R3: a grant goes only to an enabled channel that had data
    a_r1_r3_grant_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |-> (($past(ch_en) & ~$past(tx_empty) & (ONE << grant_idx)) != '0));

    // R5: full receive side blocks only transmit-and-receive channels
    a_r5_rx_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |-> ((($past(ch_txonly) | ~$past(rx_full)) & (ONE << grant_idx)) != '0));

    // R4: underflow only together with a grant
    a_r4_unf_with_load: assert property (@(posedge clk) disable iff (!rst_n)
        tx_underflow |-> load_stb);

    // R8: no new grant while a word is shifting
    a_r8_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !word_done) |=> !load_stb);

    // R10: an idle shifter with an eligible channel grants next cycle
    a_r10_idle_grants: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && elig != '0) |=> load_stb);

    // R9: a store pulse always follows an end-of-word pulse
    a_r9_store_cause: assert property (@(posedge clk) disable iff (!rst_n)
        store_stb |-> $past(word_done));

    // R7: no gated receive request for a transmit-only channel
    a_r7_rxreq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_req & $past(ch_txonly)) == '0);
endmodule

// File: tb/spi_chan_sched_test.sv
module spi_chan_sched_test;
    localparam int NCH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ch_en = '0, ch_txonly = '0, tx_empty = '0, rx_full = '0;
    logic       word_done = 1'b0;
    logic [1:0] grant_idx, store_idx;
    logic       load_stb, tx_underflow, store_stb;
    logic [3:0] rx_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    spi_chan_sched #(.NCH(NCH)) uut (
        .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .ch_txonly(ch_txonly),
        .tx_empty(tx_empty), .rx_full(rx_full), .word_done(word_done),
        .grant_idx(grant_idx), .load_stb(load_stb), .tx_underflow(tx_underflow),
        .store_stb(store_stb), .store_idx(store_idx), .rx_req(rx_req)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // {en, txonly, txempty, rxfull, word_done | load, idx, unf, store, sidx}
    localparam logic [23:0] VEC [16] = '{
        {4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0}, // R1 none enabled
        {4'b1111, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 2'd0}, // R2 starts at 0
        {4'b1111, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0}, // R8 busy
        {4'b1111, 4'b0000, 4'b0000, 4'b0000, 1'b1, 1'b1, 2'd1, 1'b0, 1'b1, 2'd0}, // R2 R9 next
        {4'b1111, 4'b0000, 4'b0100, 4'b0000, 1'b1, 1'b1, 2'd3, 1'b1, 1'b1, 2'd1}, // R3 R4 skip empty
        {4'b1111, 4'b0000, 4'b0000, 4'b0001, 1'b1, 1'b1, 2'd1, 1'b0, 1'b1, 2'd3}, // R5 wrap, rx full skip
        {4'b0001, 4'b0001, 4'b0000, 4'b0001, 1'b1, 1'b1, 2'd0, 1'b0, 1'b1, 2'd1}, // R6 tx-only granted
        {4'b0011, 4'b0000, 4'b0010, 4'b0001, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 2'd0}, // R10 none eligible
        {4'b0011, 4'b0000, 4'b0010, 4'b0001, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0}, // R10 stays idle
        {4'b0011, 4'b0000, 4'b0000, 4'b0001, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 2'd0}, // R10 wakes
        {4'b0011, 4'b0000, 4'b0000, 4'b0001, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 2'd0}, // R8
        {4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 2'd0}, // R8 still shifting
        {4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b1, 1'b0, 2'd1, 1'b0, 1'b1, 2'd1}, // R9 store, R1
        {4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 2'd0}, // R9 idle pulse ignored
        {4'b1111, 4'b0000, 4'b0001, 4'b0000, 1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 2'd0}, // R2 after ch1
        {4'b1111, 4'b0000, 4'b1001, 4'b0000, 1'b1, 1'b1, 2'd1, 1'b1, 1'b1, 2'd2}  // R4 wrap underflow
    };

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11 load", int'(load_stb), 0);
        chk("R11 grant_idx", int'(grant_idx), 0);
        chk("R11 store", int'(store_stb), 0);
        chk("R11 rx_req", int'(rx_req), 0);
        rst_n = 1'b1;

        for (int v = 0; v < 16; v++) begin
            logic [23:0] e;
            e = VEC[v];
            ch_en     = e[23:20];
            ch_txonly = e[19:16];
            tx_empty  = e[15:12];
            rx_full   = e[11:8];
            word_done = e[7];
            @(posedge clk);
            @(negedge clk);
            chk($sformatf("R8 load v%0d", v), int'(load_stb), int'(e[6]));
            chk($sformatf("R2 grant_idx v%0d", v), int'(grant_idx), int'(e[5:4]));
            chk($sformatf("R4 underflow v%0d", v), int'(tx_underflow), int'(e[3]));
            chk($sformatf("R9 store v%0d", v), int'(store_stb), int'(e[2]));
            if (e[2]) chk($sformatf("R9 store_idx v%0d", v), int'(store_idx), int'(e[1:0]));
        end
        word_done = 1'b0;

        // R7: request gating per mode
        ch_txonly = 4'b0101;
        rx_full   = 4'b1111;
        @(posedge clk);
        @(negedge clk);
        chk("R7 rx_req gated", int'(rx_req), 4'b1010);
        ch_txonly = 4'b0000;
        rx_full   = 4'b0110;
        @(posedge clk);
        @(negedge clk);
        chk("R7 rx_req pass", int'(rx_req), 4'b0110);

        // R11 / R2: reset mid-run clears state, search restarts at 0
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R11 load mid", int'(load_stb), 0);
        chk("R11 grant_idx mid", int'(grant_idx), 0);
        chk("R11 rx_req mid", int'(rx_req), 0);
        rst_n     = 1'b1;
        ch_en     = 4'b1111;
        tx_empty  = 4'b0000;
        rx_full   = 4'b0000;
        @(posedge clk);
        @(negedge clk);
        chk("R2 restart load", int'(load_stb), 1);
        chk("R2 restart idx", int'(grant_idx), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule